// File: doc/BRIEF.md
# Per-Rank Sliding-Window Activation Throttle

This block watches the row-activation commands that a memory channel issues and limits each rank to a fixed number of activations (four by default) inside a sliding window. The window length is programmable in clock cycles. Each rank keeps a short queue holding the issue times of its most recent accepted activations. The times come from one free-running cycle counter. When a rank's queue is full and its oldest entry is still inside the window, that rank's block bit is raised. The command scheduler uses the bit to hold back further activations to that rank. The bit drops on its own once the oldest recorded activation has aged out of the window.

A second activation source can be enabled. This input carries activations issued on a partner channel that runs in mirrored mode, where both channels must account for the same commands. A local activation and a mirrored activation that hit the same rank in the same cycle are one command and are counted once. The window length is captured only while no rank holds a recorded activation, so a change made in the middle of a throttling episode cannot shorten or stretch it.

Top module: `act_window_throttle`

## Requirements
- R1: While reset is held, all queues are emptied and the window register is cleared. In the first cycle after a reset edge every bit of `rank_block` is 0.
- R2: A rank is selected when `act_done` is 1 and `act_rank` carries its number as an unsigned binary value. When the fourth activation that is still inside the window is recorded at a clock edge, that rank's bit of `rank_block` (bit index equals the rank number) is 1 in the cycle right after that edge.
- R3: With a window of W cycles, a raised bit falls after the (W-1)th clock edge that follows the edge which recorded the oldest of the counted activations. It stays 1 until then.
- R4: Each rank is tracked separately. Activity on one rank never raises or lowers the bit of another rank.
- R5: An activation that arrives while its rank's bit is 1 is discarded. It is not recorded and does not delay the release.
- R6: A rank whose activations never put more than three inside any window never has its bit raised, even when it is activated every cycle.
- R7: When `mirror_mode` is 1, a pulse on `mirror_done` counts as an activation of rank `mirror_rank` (unsigned binary). When `mirror_mode` is 0, the mirrored inputs have no effect.
- R8: A local and a mirrored activation to the same rank in the same cycle are recorded as one activation.
- R9: The window length is loaded from `win_len` at every clock edge where no rank holds a recorded activation, including the edge that records the first one. While any rank holds one, changes on `win_len` are ignored. The window must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_done | input | 1 | A local activation completes this cycle |
| act_rank | input | 3 | Rank number of the local activation |
| mirror_mode | input | 1 | Count activations from the partner channel |
| mirror_done | input | 1 | A partner-channel activation completes this cycle |
| mirror_rank | input | 3 | Rank number of the partner activation |
| win_len | input | 8 | Window length in clock cycles (1 to 255) |
| rank_block | output | 8 | Per-rank block bits, bit n for rank n |

## Verification
Some properties are checked on every cycle: a block bit can only rise right after an activation that selected that rank, at most two bits can rise together, and with mirroring off only a local activation can raise a bit. The reset state is also checked every cycle. The bench's scenarios cover what those properties cannot. They check the exact release cycle, set by the age of the oldest activation, and that an activation sent to a blocked rank is discarded. They also check the single count when a local and a mirrored activation collide, and that a window change made while activations are tracked is ignored.

// File: rtl/act_window_pkg.sv
package act_window_pkg;
   localparam int unsigned DEF_RANKS = 8;
   localparam int unsigned DEF_LIMIT = 4;
   localparam int unsigned DEF_TS_W  = 8;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/act_hit_decode.sv
module act_hit_decode
   import act_window_pkg::*;
#(
   parameter int unsigned NUM_RANKS = DEF_RANKS,
   parameter bit          MIRROR_EN = 1'b1,
   localparam int unsigned RANK_W   = idx_width(NUM_RANKS)
) (
   input  logic                 loc_vld,
   input  logic [RANK_W-1:0]    loc_rank,
   input  logic                 mir_mode,
   input  logic                 mir_vld,
   input  logic [RANK_W-1:0]    mir_rank,
   output logic [NUM_RANKS-1:0] hit
);
   logic [NUM_RANKS-1:0] loc_hit;

   always_comb begin
      for (int r = 0; r < NUM_RANKS; r++)
         loc_hit[r] = loc_vld && (loc_rank == RANK_W'(r));
   end

   generate
      if (MIRROR_EN) begin : g_mirror
         logic [NUM_RANKS-1:0] mir_hit;
         always_comb begin
            for (int r = 0; r < NUM_RANKS; r++)
               mir_hit[r] = mir_mode && mir_vld && (mir_rank == RANK_W'(r));
         end
         // a collision on one rank merges into a single hit
         assign hit = loc_hit | mir_hit;
      end else begin : g_local_only
         assign hit = loc_hit;
      end
   endgenerate
endmodule

// File: rtl/rank_ts_window.sv
module rank_ts_window
   import act_window_pkg::*;
#(
   parameter int unsigned LIMIT = DEF_LIMIT,
   parameter int unsigned TS_W  = DEF_TS_W,
   localparam int unsigned CNT_W = idx_width(LIMIT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] now,
   input  logic [TS_W-1:0] win,
   input  logic            hit,
   output logic            blocked,
   output logic            empty
);
   logic [TS_W-1:0]  ts_q [LIMIT];
   logic [TS_W-1:0]  ts_d [LIMIT];
   logic [CNT_W-1:0] cnt_q, cnt_d, wr_idx;
   logic [TS_W-1:0]  age;
   logic             expired, full, pop, push;

   assign age     = now - ts_q[0];
   assign expired = (age >= win);
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(LIMIT));
   assign blocked = full && !expired;
   // only the oldest entry can age out first; one drop per cycle keeps pace
   assign pop     = !empty && expired;
   assign push    = hit && !blocked;
   assign wr_idx  = pop ? (cnt_q - CNT_W'(1)) : cnt_q;

   always_comb begin
      unique case ({push, pop})
         2'b10:   cnt_d = cnt_q + CNT_W'(1);
         2'b01:   cnt_d = cnt_q - CNT_W'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   genvar i;
   generate
      for (i = 0; i < LIMIT; i++) begin : g_slot
         logic [TS_W-1:0] shifted;
         if (i < LIMIT - 1) begin : g_shift
            assign shifted = pop ? ts_q[i+1] : ts_q[i];
         end else begin : g_tail
            assign shifted = ts_q[i];
         end
         assign ts_d[i] = (push && (wr_idx == CNT_W'(i))) ? now : shifted;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < LIMIT; k++) ts_q[k] <= '0;
      end else begin
         cnt_q <= cnt_d;
         ts_q  <= ts_d;
      end
   end
endmodule

// File: rtl/act_window_throttle.sv
module act_window_throttle
   import act_window_pkg::*;
#(
   parameter int unsigned NUM_RANKS = DEF_RANKS,
   parameter int unsigned LIMIT     = DEF_LIMIT,
   parameter int unsigned TS_W      = DEF_TS_W,
   parameter bit          MIRROR_EN = 1'b1,
   localparam int unsigned RANK_W   = idx_width(NUM_RANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act_done,
   input  logic [RANK_W-1:0]    act_rank,
   input  logic                 mirror_mode,
   input  logic                 mirror_done,
   input  logic [RANK_W-1:0]    mirror_rank,
   input  logic [TS_W-1:0]      win_len,
   output logic [NUM_RANKS-1:0] rank_block
);
   generate
      if (NUM_RANKS < 2) begin : g_bad_ranks
         $error("act_window_throttle: NUM_RANKS must be at least 2");
      end
      if (LIMIT < 1) begin : g_bad_limit
         $error("act_window_throttle: LIMIT must be at least 1");
      end
      if (TS_W < 2 || TS_W > 32) begin : g_bad_ts
         $error("act_window_throttle: TS_W must lie in 2..32");
      end
   endgenerate

   logic [TS_W-1:0]      now_q, win_q;
   logic [NUM_RANKS-1:0] hit, empty_vec;
   logic                 all_empty;

   act_hit_decode #(.NUM_RANKS(NUM_RANKS), .MIRROR_EN(MIRROR_EN)) u_dec (
      .loc_vld (act_done),
      .loc_rank(act_rank),
      .mir_mode(mirror_mode),
      .mir_vld (mirror_done),
      .mir_rank(mirror_rank),
      .hit     (hit)
   );

   assign all_empty = &empty_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q <= '0;
         win_q <= '0;
      end else begin
         now_q <= now_q + TS_W'(1);
         if (all_empty) win_q <= win_len;
      end
   end

   genvar r;
   generate
      for (r = 0; r < NUM_RANKS; r++) begin : g_rank
         rank_ts_window #(.LIMIT(LIMIT), .TS_W(TS_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .now    (now_q),
            .win    (win_q),
            .hit    (hit[r]),
            .blocked(rank_block[r]),
            .empty  (empty_vec[r])
         );
      end
   endgenerate
endmodule

// File: rtl/act_window_throttle_chk.sv
module act_window_throttle_chk
   import act_window_pkg::*;
#(
   parameter int unsigned NUM_RANKS = DEF_RANKS,
   parameter bit          MIRROR_EN = 1'b1,
   localparam int unsigned RANK_W   = idx_width(NUM_RANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 act_done,
   input logic [RANK_W-1:0]    act_rank,
   input logic                 mirror_mode,
   input logic                 mirror_done,
   input logic [RANK_W-1:0]    mirror_rank,
   input logic [NUM_RANKS-1:0] rank_block
);
   logic [NUM_RANKS-1:0] sel_loc, sel_any;

   always_comb begin
      for (int r = 0; r < NUM_RANKS; r++) begin
         sel_loc[r] = act_done && (act_rank == RANK_W'(r));
         sel_any[r] = sel_loc[r] ||
                      (MIRROR_EN && mirror_mode && mirror_done && (mirror_rank == RANK_W'(r)));
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (rank_block == '0));

   assert_rise_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rank_block & ~$past(rank_block)) <= 2);

   genvar r;
   generate
      for (r = 0; r < NUM_RANKS; r++) begin : g_rank_chk
         assert_rise_needs_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rank_block[r]) |-> $past(sel_any[r]));

         assert_mirror_off_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(rank_block[r]) && !$past(mirror_mode)) |-> $past(sel_loc[r]));
      end
   endgenerate
endmodule

bind act_window_throttle act_window_throttle_chk #(
   .NUM_RANKS(NUM_RANKS),
   .MIRROR_EN(MIRROR_EN)
) u_chk (.*);

// File: tb/sim_act_window_throttle.sv
`timescale 1ns/1ps
module sim_act_window_throttle;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       act_done = 1'b0;
   logic [2:0] act_rank = '0;
   logic       mirror_mode = 1'b0;
   logic       mirror_done = 1'b0;
   logic [2:0] mirror_rank = '0;
   logic [7:0] win_len = 8'd8;
   logic [7:0] rank_block;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   act_window_throttle u0 (
      .clk(clk), .rst_n(rst_n), .act_done(act_done), .act_rank(act_rank),
      .mirror_mode(mirror_mode), .mirror_done(mirror_done), .mirror_rank(mirror_rank),
      .win_len(win_len), .rank_block(rank_block)
   );

   // {act, rank[2:0], mirror_mode, mirror_done, mirror_rank[2:0], expected block[7:0]}, window 8
   localparam logic [16:0] VEC [24] = '{
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h04},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h04},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h04},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h04},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd5, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b1, 3'd6, 1'b1, 1'b1, 3'd6, 8'h00},
      {1'b0, 3'd0, 1'b1, 1'b1, 3'd6, 8'h00},
      {1'b1, 3'd6, 1'b1, 1'b1, 3'd6, 8'h00},
      {1'b1, 3'd1, 1'b1, 1'b1, 3'd6, 8'h40},
      {1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 8'h40},
      {1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 8'h40},
      {1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 8'h40},
      {1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 8'h02},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h02},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h02},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00},
      {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00}
   };

   function automatic string row_req(input int i);
      if (i <= 3)       return "R2";
      else if (i <= 6)  return "R5";
      else if (i <= 11) return "R3";
      else if (i <= 15) return "R8";
      else if (i <= 18) return "R7";
      else              return "R4";
   endfunction

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: rank_block=%h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // drive one cycle of inputs at a falling edge, return at the next falling edge
   task automatic step(input logic a, input logic [2:0] ar, input logic mm,
                       input logic md, input logic [2:0] mr);
      act_done = a; act_rank = ar; mirror_mode = mm; mirror_done = md; mirror_rank = mr;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 after reset", rank_block, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < 24; i++) begin
         step(VEC[i][16], VEC[i][15:13], VEC[i][12], VEC[i][11], VEC[i][10:8]);
         check(row_req(i), rank_block, VEC[i][7:0]);
      end

      // drain, then latch a 20-cycle window and change it mid-episode
      repeat (12) step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
      win_len = 8'd20;
      step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
      for (int k = 0; k < 4; k++) begin
         step(1'b1, 3'd3, 1'b0, 1'b0, 3'd0);
         win_len = 8'd2;
         check("R2 rank3", rank_block, (k == 3) ? 8'h08 : 8'h00);
      end
      for (int k = 4; k < 20; k++) begin
         step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
         if (k == 18)      check("R9 window held", rank_block, 8'h08);
         else if (k == 19) check("R3 release", rank_block, 8'h00);
         else              check("R3 hold", rank_block, 8'h08);
      end

      // window 2 latched once idle: activation every cycle never blocks
      repeat (8) step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
      for (int k = 0; k < 8; k++) begin
         step(1'b1, 3'd0, 1'b0, 1'b0, 3'd0);
         check("R6 steady stream", rank_block, 8'h00);
      end

      step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 second reset", rank_block, 8'h00);
      rst_n = 1'b1;
      step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0);
      check("R1 after release", rank_block, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule